// File: doc/BRIEF.md
# Receive Buffer with Fill-Level Interrupt

This block holds characters that a serial receiver has already assembled, until software collects them through a data register read. Each stored word is 12 bits wide: the character in bits 7:0 and the receive error indications above it, with bit 10 marking a line break. The line side offers words, or a break event, and may only hand one over while the block reports itself ready. The bus side presents a read strobe and samples the word at the head of the buffer in the same cycle.

Storage is a circular buffer addressed by a head position and an occupancy count. The slot for a new word is the head plus the count, wrapping at the buffer depth. A buffer-enable input, driven from a line-control bit, chooses between the full depth and a single-entry holding register. The block keeps empty and full flags and drives a receive interrupt request that follows the fill count against a trigger level, which is fixed at one.

Top module: `rx_trigger_fifo`

## Requirements
- R1: After reset the count and head are zero, emptyFlag is 1, fullFlag is 0, rxIrq is 0 and lineReady is 1.
- R2: Words are returned by dataRead in the order they were accepted, across wrap of the 16-slot storage, with dataOut valid in the same cycle as the strobe.
- R3: With bufEnable at 1, lineReady is 1 while fewer than 16 words are held.
- R4: With bufEnable at 0, lineReady is 1 only while the buffer is empty, so at most one word is held.
- R5: A word or break offered while lineReady is 0 is dropped; the contents and count are unchanged.
- R6: A lineBreak event is stored as 0x400 (bit 10 set, all other bits zero); if lineValid is also high in that cycle the break wins and the data word is dropped.
- R7: An accepted push clears emptyFlag; a read that leaves the count at zero sets it.
- R8: A push that brings the count to 16 sets fullFlag; any read clears it.
- R9: A read while empty returns the word at the head slot and leaves head, count and flags unchanged.
- R10: rxIrq rises when a push makes the count equal to the trigger level.
- R11: rxIrq falls when a read makes the count one below the trigger level.
- R12: A push and a read in the same cycle leave the count unchanged (a read of an empty buffer does not pop, so the count becomes 1), and flags follow the resulting count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bufEnable | input | 1 | 1: full depth, 0: single-entry mode |
| lineValid | input | 1 | Line side offers lineWord |
| lineWord | input | 12 | Received character with error bits |
| lineBreak | input | 1 | Line side reports a break |
| lineReady | output | 1 | Block can accept a word this cycle |
| dataRead | input | 1 | Data register read strobe |
| dataOut | output | 12 | Word at the head, valid with dataRead |
| emptyFlag | output | 1 | No words held |
| fullFlag | output | 1 | All 16 slots held |
| rxIrq | output | 1 | Receive interrupt request |

## Verification
dataOut is combinational from the head slot, so the bench checks it in the same cycle as the read strobe, a few nanoseconds after driving it and before the rising edge. lineReady, emptyFlag, fullFlag and rxIrq are registered or derived from registered state, so a push or read is seen on them one edge later; the bench checks them at the falling edge following that edge, before driving the next operation. A reference model of head, count and slot contents is advanced at each edge, and read data is compared only for slots the model knows were written.

// File: rtl/rx_fifo_pkg.sv
package rx_fifo_pkg;
  localparam int unsigned WORD_W = 12;
  localparam int unsigned BREAK_BIT = 10;

  // Strobes from control to datapath
  typedef struct packed {
    logic wrEn;
    logic isBreak;
  } rxStrobe_t;
endpackage

// File: rtl/rx_fifo_ctrl.sv
module rx_fifo_ctrl #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned TRIG_LEVEL = 1,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic clk,
  input  logic rstN,
  input  logic bufEnable,
  input  logic lineValid,
  input  logic lineBreak,
  input  logic dataRead,
  output logic lineReady,
  output rx_fifo_pkg::rxStrobe_t strobe,
  output logic [PTR_W-1:0] wrIdx,
  output logic [PTR_W-1:0] rdIdx,
  output logic emptyFlag,
  output logic fullFlag,
  output logic rxIrq
);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] TRIG_C = CNT_W'(TRIG_LEVEL);

  logic [PTR_W-1:0] headQ;
  logic [CNT_W-1:0] countQ, countNext;
  logic emptyQ, fullQ, irqQ;
  logic pushReq, doPush, doPop;

  assign pushReq = lineValid | lineBreak;
  assign lineReady = bufEnable ? (countQ < DEPTH_C) : (countQ == '0);
  assign doPush = pushReq & lineReady;
  assign doPop = dataRead & (countQ != '0);
  assign countNext = countQ + CNT_W'(doPush) - CNT_W'(doPop);

  assign strobe.wrEn = doPush;
  assign strobe.isBreak = lineBreak;
  assign wrIdx = headQ + PTR_W'(countQ);
  assign rdIdx = headQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      headQ <= '0;
      countQ <= '0;
      emptyQ <= 1'b1;
      fullQ <= 1'b0;
      irqQ <= 1'b0;
    end else begin
      countQ <= countNext;
      if (doPop) headQ <= headQ + 1'b1;
      if (doPush || dataRead) begin
        emptyQ <= (countNext == '0);
        fullQ <= (countNext == DEPTH_C);
      end
      if (doPush && !doPop && countNext == TRIG_C) irqQ <= 1'b1;
      else if (doPop && !doPush && countNext == TRIG_C - 1'b1) irqQ <= 1'b0;
    end
  end

  assign emptyFlag = emptyQ;
  assign fullFlag = fullQ;
  assign rxIrq = irqQ;

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    countQ <= DEPTH_C);
  // R4
  single_depth_chk: assert property (@(posedge clk) disable iff (!rstN)
    !bufEnable && doPush |=> countQ == 5'd1 || countQ == CNT_W'(1));
  // R5
  drop_keeps_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    pushReq && !lineReady && !dataRead |=> $stable(countQ) && $stable(headQ));
  // R7
  empty_track_chk: assert property (@(posedge clk) disable iff (!rstN)
    emptyQ == (countQ == '0));
  // R8
  full_track_chk: assert property (@(posedge clk) disable iff (!rstN)
    fullQ == (countQ == DEPTH_C));
  // R10
  irq_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqQ == (countQ >= TRIG_C));
  // R9
  empty_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    dataRead && emptyQ && !pushReq |=> $stable(headQ) && emptyQ);
endmodule

// File: rtl/rx_fifo_store.sv
module rx_fifo_store #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned WORD_W = rx_fifo_pkg::WORD_W,
  parameter int unsigned BREAK_BIT = rx_fifo_pkg::BREAK_BIT,
  localparam int unsigned PTR_W = $clog2(DEPTH)
) (
  input  logic clk,
  input  rx_fifo_pkg::rxStrobe_t strobe,
  input  logic [PTR_W-1:0] wrIdx,
  input  logic [PTR_W-1:0] rdIdx,
  input  logic [WORD_W-1:0] lineWord,
  output logic [WORD_W-1:0] dataOut
);
  localparam logic [WORD_W-1:0] BREAK_WORD = WORD_W'(1) << BREAK_BIT;

  logic [WORD_W-1:0] slots [DEPTH];
  logic [WORD_W-1:0] wrWord;

  assign wrWord = strobe.isBreak ? BREAK_WORD : lineWord;

  always_ff @(posedge clk) begin
    if (strobe.wrEn) slots[wrIdx] <= wrWord;
  end

  assign dataOut = slots[rdIdx];

  // R6
  break_word_chk: assert property (@(posedge clk)
    strobe.wrEn && strobe.isBreak |=> slots[$past(wrIdx)] == BREAK_WORD);
endmodule

// File: rtl/rx_trigger_fifo.sv
module rx_trigger_fifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned TRIG_LEVEL = 1,
  parameter int unsigned WORD_W = rx_fifo_pkg::WORD_W,
  localparam int unsigned PTR_W = $clog2(DEPTH)
) (
  input  logic clk,
  input  logic rstN,
  input  logic bufEnable,
  input  logic lineValid,
  input  logic [WORD_W-1:0] lineWord,
  input  logic lineBreak,
  output logic lineReady,
  input  logic dataRead,
  output logic [WORD_W-1:0] dataOut,
  output logic emptyFlag,
  output logic fullFlag,
  output logic rxIrq
);
  rx_fifo_pkg::rxStrobe_t strobe;
  logic [PTR_W-1:0] wrIdx, rdIdx;

  rx_fifo_ctrl #(.DEPTH(DEPTH), .TRIG_LEVEL(TRIG_LEVEL)) uCtrl (
    .clk(clk), .rstN(rstN), .bufEnable(bufEnable), .lineValid(lineValid),
    .lineBreak(lineBreak), .dataRead(dataRead), .lineReady(lineReady),
    .strobe(strobe), .wrIdx(wrIdx), .rdIdx(rdIdx), .emptyFlag(emptyFlag),
    .fullFlag(fullFlag), .rxIrq(rxIrq)
  );

  rx_fifo_store #(.DEPTH(DEPTH), .WORD_W(WORD_W)) uStore (
    .clk(clk), .strobe(strobe), .wrIdx(wrIdx), .rdIdx(rdIdx),
    .lineWord(lineWord), .dataOut(dataOut)
  );

  // R11
  irq_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rxIrq) |-> emptyFlag);
endmodule

// File: tb/sim_rx_trigger_fifo.sv
module sim_rx_trigger_fifo;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bufEnable = 1'b1, lineValid = 1'b0, lineBreak = 1'b0, dataRead = 1'b0;
  logic [11:0] lineWord = '0;
  logic lineReady, emptyFlag, fullFlag, rxIrq;
  logic [11:0] dataOut;

  int total = 0, bad = 0;
  bit finished = 0;
  logic [11:0] mMem [16];
  bit mValid [16];
  int mHead = 0, mCnt = 0;

  always #10 clk = ~clk;

  rx_trigger_fifo u0 (
    .clk(clk), .rstN(rstN), .bufEnable(bufEnable), .lineValid(lineValid),
    .lineWord(lineWord), .lineBreak(lineBreak), .lineReady(lineReady),
    .dataRead(dataRead), .dataOut(dataOut), .emptyFlag(emptyFlag),
    .fullFlag(fullFlag), .rxIrq(rxIrq)
  );

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit expReady(bit en);
    return en ? (mCnt < 16) : (mCnt == 0);
  endfunction

  task automatic checkState(string tag);
    check({tag, " R7 empty"}, int'(emptyFlag), int'(mCnt == 0));
    check({tag, " R8 full"}, int'(fullFlag), int'(mCnt == 16));
    check({tag, " R10/R11 irq"}, int'(rxIrq), int'(mCnt >= 1));
    check({tag, " R3/R4 ready"}, int'(lineReady), int'(expReady(bufEnable)));
  endtask

  task automatic step(bit p, bit b, logic [11:0] d, bit r, bit en, string tag);
    bit dp, dq;
    @(negedge clk);
    bufEnable = en;
    #1;
    checkState(tag);
    lineValid = p; lineBreak = b; lineWord = d; dataRead = r;
    #2;
    if (r && mValid[mHead])
      check({tag, " R2/R9 data"}, int'(dataOut), int'(mMem[mHead]));
    dp = (p || b) && expReady(en);
    dq = r && (mCnt != 0);
    if (dp) begin
      mMem[(mHead + mCnt) % 16] = b ? 12'h400 : d;
      mValid[(mHead + mCnt) % 16] = 1;
    end
    if (dq) mHead = (mHead + 1) % 16;
    mCnt = mCnt + int'(dp) - int'(dq);
    @(posedge clk);
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) mValid[i] = 0;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 empty", int'(emptyFlag), 1);
    check("R1 full", int'(fullFlag), 0);
    check("R1 irq", int'(rxIrq), 0);
    check("R1 ready", int'(lineReady), 1);
    // R10 single push raises irq
    step(1, 0, 12'h0A5, 0, 1, "R10 first");
    // R3 fill to 16 with wrap later
    for (int i = 1; i < 16; i++) step(1, 0, 12'(i + 12'h100), 0, 1, "R3 fill");
    step(0, 0, 0, 0, 1, "R8 full");
    // R5 push while full is dropped
    step(1, 0, 12'hFFF, 0, 1, "R5 drop");
    step(0, 0, 0, 0, 1, "R5 after");
    check("R5 count", mCnt, 16);
    // R2 drain in order
    for (int i = 0; i < 16; i++) step(0, 0, 0, 1, 1, "R2 drain");
    step(0, 0, 0, 0, 1, "R11 drained");
    // R9 read of empty
    step(0, 0, 0, 1, 1, "R9 empty read");
    step(0, 0, 0, 0, 1, "R9 after");
    // R6 break, also with data in same cycle
    step(0, 1, 0, 0, 1, "R6 break");
    step(1, 1, 12'h0FF, 0, 1, "R6 both");
    step(0, 0, 0, 1, 1, "R6 read");
    step(0, 0, 0, 1, 1, "R6 read");
    step(0, 0, 0, 0, 1, "R6 after");
    // R4 single-entry mode
    step(1, 0, 12'h033, 0, 0, "R4 push");
    step(1, 0, 12'h044, 0, 0, "R4 drop");
    step(0, 0, 0, 1, 0, "R4 read");
    step(0, 0, 0, 0, 0, "R4 after");
    // R12 simultaneous push and read at empty and at mid fill
    step(1, 0, 12'h055, 1, 1, "R12 at empty");
    step(1, 0, 12'h066, 0, 1, "R12 fill");
    step(1, 0, 12'h077, 1, 1, "R12 mid");
    step(0, 0, 0, 0, 1, "R12 after");
    check("R12 count", mCnt, 2);
    // constrained random
    for (int n = 0; n < 3000; n++) begin
      int sel = $urandom % 100;
      bit en = (n % 500) < 400 ? 1'b1 : (sel < 50);
      step(($urandom % 100) < 55, ($urandom % 100) < 5, 12'($urandom),
           ($urandom % 100) < 45, en, "rand");
    end
    step(0, 0, 0, 0, 1, "final");
    @(negedge clk);
    checkState("final");
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule